// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an external parallel NOR flash. It accepts one request at a time on a valid/ready interface: program one location, erase one sector, erase the whole chip, read an identifier, or return the device to read mode. For each request it produces the keyed series of bus write cycles that the flash expects. Each cycle drives chip-enable, write-enable and output-enable strobes whose setup, low and recovery intervals are given as clock counts.

After a program or erase command, the sequencer reads the device again and again until the self-timed internal operation ends. It recognises the end in one of two ways, chosen per request: data bit 7 reaching its final value, or bit 6 no longer changing between two reads. Every operation has its own timeout. When the timeout expires, the sequencer writes a reset command and then reports the failure. An input selects byte or word addressing, and that choice sets the two key addresses used in the unlock cycles.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: `req_op` codes are 0 reset, 1 program, 2 sector erase, 3 chip erase and 4 read identifier. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is 0 from the next cycle until the cycle in which `done_valid` pulses. After reset, `req_ready` is 1, `done_valid` is 0, all three strobes are high and `fl_dq_oe` is 0.
- R2: A program request writes these four cycles in order: AAh to key A, 55h to key B, A0h to key A, and finally `req_data` to `req_addr`.
- R3: A sector erase writes six cycles: AAh to key A, 55h to key B, 80h to key A, AAh to key A, 55h to key B, then 30h to `req_addr`. A chip erase writes the same first five cycles and ends with 10h to key A.
- R4: Key A is 5555h and key B is 2AAAh when `byte_mode`=0. Key A is AAAAh and key B is 5555h when `byte_mode`=1.
- R5: A reset request, and any `req_op` code from 5 to 7, writes the single cycle F0h to key A and finishes with `done_ok`=1.
- R6: A read-identifier request writes AAh to key A, 55h to key B and 90h to key A. It then reads once at `req_addr` and returns the value read on `done_data`. It ends by writing F0h to key A, with `done_ok`=1.
- R7: Every write cycle holds `fl_we_n` low for exactly WE_LO_CYC clocks. Address and data stay unchanged while `fl_we_n` is low, and `fl_we_n` stays high for at least WE_HI_CYC clocks between two low phases.
- R8: `fl_we_n` and `fl_oe_n` are never low together. `fl_ce_n` is low whenever either strobe is low. `fl_dq_oe` is 1 only while `fl_oe_n` is high.
- R9: With `req_poll_toggle`=0, polling ends successfully at the first read whose bit 7 equals bit 7 of `req_data` for a program, or equals 1 for an erase. Until then the sequencer keeps issuing reads.
- R10: With `req_poll_toggle`=1, polling ends successfully at the first read whose bit 6 equals bit 6 of the read just before it.
- R11: If polling has run for at least the operation's limit (PROG_TMO, SERASE_TMO or CERASE_TMO clocks) when a read fails to show completion, the sequencer writes F0h to key A. It then finishes with `done_timeout`=1 and `done_ok`=0.
- R12: `done_valid` is high for exactly one clock per request. Whenever it is high, exactly one of `done_ok` and `done_timeout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Target, sector or identifier address |
| req_data | input | DW | Value to program |
| req_poll_toggle | input | 1 | 1 selects bit-6 toggle polling, 0 selects bit-7 polling |
| byte_mode | input | 1 | 1 selects byte-mode key addresses |
| done_valid | output | 1 | One-clock completion pulse |
| done_ok | output | 1 | Last request succeeded |
| done_timeout | output | 1 | Last request timed out |
| done_data | output | DW | Identifier value from a read-identifier request |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Data driven towards the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | DW | Data returned by the flash |

## Verification
The bench builds the sequencer with short strobes: 1 setup clock, 3 low clocks, 2 recovery clocks and 3 read clocks. One poll read therefore costs only a few clocks. It also shrinks the timeout limits to 300, 600 and 900 clocks for program, sector erase and chip erase. With these values, a flash model that stays busy for thousands of reads drives the timeout-and-reset path within a few dozen polls. The successful cases still finish well inside every limit. Word and byte key addresses, both polling methods and both values of data bit 7 are covered.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam logic [2:0] OPC_RESET  = 3'd0;
  localparam logic [2:0] OPC_PROG   = 3'd1;
  localparam logic [2:0] OPC_SERASE = 3'd2;
  localparam logic [2:0] OPC_CERASE = 3'd3;
  localparam logic [2:0] OPC_READID = 3'd4;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ESET  = 8'h80;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_IDENT = 8'h90;
  localparam logic [7:0] CODE_EXIT  = 8'hF0;

  typedef enum logic [1:0] {BC_IDLE, BC_SETUP, BC_STROBE, BC_RECOV} bc_state_e;
  typedef enum logic [1:0] {PH_CMD, PH_POLL, PH_ABORT} phase_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_POLL, SQ_ABORT} sq_state_e;
endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int SETUP_CYC = 1,
  parameter int WE_LO_CYC = 5,
  parameter int WE_HI_CYC = 4,
  parameter int RD_LO_CYC = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_i
);
  import nor_seq_pkg::*;

  localparam int M1 = (SETUP_CYC > WE_LO_CYC) ? SETUP_CYC : WE_LO_CYC;
  localparam int M2 = (WE_HI_CYC > RD_LO_CYC) ? WE_HI_CYC : RD_LO_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  bc_state_e     st;
  logic [CW-1:0] cnt;
  logic          is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= BC_IDLE;
      cnt    <= '0;
      is_wr  <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
      ce_n   <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      addr_o <= '0;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        BC_IDLE: if (start) begin
          ce_n   <= 1'b0;
          addr_o <= addr;
          dq_o   <= wr ? wdata : '0;
          dq_oe  <= wr;
          is_wr  <= wr;
          cnt    <= CW'(SETUP_CYC - 1);
          st     <= BC_SETUP;
        end
        BC_SETUP: if (cnt == '0) begin
          if (is_wr) begin
            we_n <= 1'b0;
            cnt  <= CW'(WE_LO_CYC - 1);
          end else begin
            oe_n <= 1'b0;
            cnt  <= CW'(RD_LO_CYC - 1);
          end
          st <= BC_STROBE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        BC_STROBE: if (cnt == '0) begin
          we_n <= 1'b1;
          oe_n <= 1'b1;
          if (!is_wr) rdata <= dq_i;
          cnt <= CW'(WE_HI_CYC - 1);
          st  <= BC_RECOV;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (cnt == '0) begin
          ce_n  <= 1'b1;
          dq_oe <= 1'b0;
          done  <= 1'b1;
          st    <= BC_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_step_gen.sv
module nor_step_gen #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  nor_seq_pkg::phase_e phase,
  input  logic [2:0]          op,
  input  logic [2:0]          idx,
  input  logic                byte_mode,
  input  logic [AW-1:0]       tgt_addr,
  input  logic [DW-1:0]       tgt_data,
  output logic                st_wr,
  output logic [AW-1:0]       st_addr,
  output logic [DW-1:0]       st_data,
  output logic [2:0]          last_idx
);
  import nor_seq_pkg::*;

  logic [AW-1:0] key_a, key_b;
  assign key_a = byte_mode ? AW'(16'hAAAA) : AW'(16'h5555);
  assign key_b = byte_mode ? AW'(16'h5555) : AW'(16'h2AAA);

  function automatic logic [DW-1:0] cmd(input logic [7:0] c);
    return DW'(c);
  endfunction

  always_comb begin
    case (op)
      OPC_PROG:               last_idx = 3'd3;
      OPC_SERASE, OPC_CERASE: last_idx = 3'd5;
      OPC_READID:             last_idx = 3'd4;
      default:                last_idx = 3'd0;
    endcase
  end

  always_comb begin
    st_wr   = 1'b1;
    st_addr = key_a;
    st_data = cmd(CODE_EXIT);
    if (phase == PH_POLL) begin
      st_wr   = 1'b0;
      st_addr = tgt_addr;
      st_data = '0;
    end else if (phase == PH_CMD) begin
      if (op == OPC_PROG || op == OPC_SERASE || op == OPC_CERASE || op == OPC_READID) begin
        case (idx)
          3'd0: st_data = cmd(KEY_FIRST);
          3'd1: begin st_addr = key_b; st_data = cmd(KEY_SECOND); end
          3'd2: begin
            if (op == OPC_PROG)        st_data = cmd(CODE_PROG);
            else if (op == OPC_READID) st_data = cmd(CODE_IDENT);
            else                       st_data = cmd(CODE_ESET);
          end
          3'd3: begin
            if (op == OPC_PROG) begin
              st_addr = tgt_addr;
              st_data = tgt_data;
            end else if (op == OPC_READID) begin
              st_wr   = 1'b0;
              st_addr = tgt_addr;
              st_data = '0;
            end else begin
              st_data = cmd(KEY_FIRST);
            end
          end
          3'd4: begin
            if (op != OPC_READID) begin
              st_addr = key_b;
              st_data = cmd(KEY_SECOND);
            end
          end
          default: begin
            if (op == OPC_SERASE) begin
              st_addr = tgt_addr;
              st_data = cmd(CODE_SECT);
            end else begin
              st_data = cmd(CODE_CHIP);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl #(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int TW = 32,
  parameter int PROG_TMO = 4000,
  parameter int SERASE_TMO = 2000000,
  parameter int CERASE_TMO = 2000000000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_op,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_data,
  input  logic                 req_poll_toggle,
  input  logic                 byte_mode,
  output nor_seq_pkg::phase_e  phase,
  output logic [2:0]           op_q,
  output logic [2:0]           idx,
  output logic                 byte_q,
  output logic [AW-1:0]        addr_q,
  output logic [DW-1:0]        data_q,
  input  logic [2:0]           last_idx,
  output logic                 go,
  input  logic                 bus_done,
  input  logic [DW-1:0]        bus_rdata,
  output logic                 done_valid,
  output logic                 done_ok,
  output logic                 done_timeout,
  output logic [DW-1:0]        done_data
);
  import nor_seq_pkg::*;

  sq_state_e     st;
  logic [TW-1:0] tmo;
  logic [TW-1:0] limit;
  logic          tog_q, first, prev6, exp7, hit, polled;

  always_comb begin
    case (op_q)
      OPC_PROG:   limit = TW'(PROG_TMO);
      OPC_SERASE: limit = TW'(SERASE_TMO);
      default:    limit = TW'(CERASE_TMO);
    endcase
  end

  assign exp7   = (op_q == OPC_PROG) ? data_q[7] : 1'b1;
  assign hit    = tog_q ? (!first && (bus_rdata[6] == prev6)) : (bus_rdata[7] == exp7);
  assign polled = (op_q == OPC_PROG) || (op_q == OPC_SERASE) || (op_q == OPC_CERASE);

  always_comb begin
    case (st)
      SQ_POLL:  phase = PH_POLL;
      SQ_ABORT: phase = PH_ABORT;
      default:  phase = PH_CMD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= SQ_IDLE;
      req_ready    <= 1'b1;
      op_q         <= '0;
      idx          <= '0;
      byte_q       <= 1'b0;
      addr_q       <= '0;
      data_q       <= '0;
      tog_q        <= 1'b0;
      first        <= 1'b1;
      prev6        <= 1'b0;
      tmo          <= '0;
      go           <= 1'b0;
      done_valid   <= 1'b0;
      done_ok      <= 1'b0;
      done_timeout <= 1'b0;
      done_data    <= '0;
    end else begin
      go         <= 1'b0;
      done_valid <= 1'b0;
      case (st)
        SQ_IDLE: if (req_valid && req_ready) begin
          op_q      <= req_op;
          addr_q    <= req_addr;
          data_q    <= req_data;
          byte_q    <= byte_mode;
          tog_q     <= req_poll_toggle;
          idx       <= '0;
          req_ready <= 1'b0;
          go        <= 1'b1;
          st        <= SQ_CMD;
        end
        SQ_CMD: if (bus_done) begin
          if (op_q == OPC_READID && idx == 3'd3) done_data <= bus_rdata;
          if (idx == last_idx) begin
            if (polled) begin
              st    <= SQ_POLL;
              tmo   <= '0;
              first <= 1'b1;
              go    <= 1'b1;
            end else begin
              st           <= SQ_IDLE;
              req_ready    <= 1'b1;
              done_valid   <= 1'b1;
              done_ok      <= 1'b1;
              done_timeout <= 1'b0;
            end
          end else begin
            idx <= idx + 1'b1;
            go  <= 1'b1;
          end
        end
        SQ_POLL: begin
          tmo <= tmo + 1'b1;
          if (bus_done) begin
            prev6 <= bus_rdata[6];
            first <= 1'b0;
            if (hit) begin
              st           <= SQ_IDLE;
              req_ready    <= 1'b1;
              done_valid   <= 1'b1;
              done_ok      <= 1'b1;
              done_timeout <= 1'b0;
            end else if (tmo >= limit) begin
              st <= SQ_ABORT;
              go <= 1'b1;
            end else begin
              go <= 1'b1;
            end
          end
        end
        default: if (bus_done) begin
          st           <= SQ_IDLE;
          req_ready    <= 1'b1;
          done_valid   <= 1'b1;
          done_ok      <= 1'b0;
          done_timeout <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer #(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int TW = 32,
  parameter int SETUP_CYC = 1,
  parameter int WE_LO_CYC = 5,
  parameter int WE_HI_CYC = 4,
  parameter int RD_LO_CYC = 12,
  parameter int PROG_TMO = 4000,
  parameter int SERASE_TMO = 2000000,
  parameter int CERASE_TMO = 2000000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_poll_toggle,
  input  logic          byte_mode,
  output logic          done_valid,
  output logic          done_ok,
  output logic          done_timeout,
  output logic [DW-1:0] done_data,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);
  nor_seq_pkg::phase_e phase;
  logic [2:0]    op_q, idx, last_idx;
  logic          byte_q, go, bus_done, st_wr;
  logic [AW-1:0] addr_q, st_addr;
  logic [DW-1:0] data_q, st_data, bus_rdata;

  nor_seq_ctrl #(
    .AW(AW), .DW(DW), .TW(TW),
    .PROG_TMO(PROG_TMO), .SERASE_TMO(SERASE_TMO), .CERASE_TMO(CERASE_TMO)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .req_poll_toggle(req_poll_toggle), .byte_mode(byte_mode),
    .phase(phase), .op_q(op_q), .idx(idx), .byte_q(byte_q),
    .addr_q(addr_q), .data_q(data_q), .last_idx(last_idx),
    .go(go), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .done_valid(done_valid), .done_ok(done_ok),
    .done_timeout(done_timeout), .done_data(done_data)
  );

  nor_step_gen #(.AW(AW), .DW(DW)) u_step (
    .phase(phase), .op(op_q), .idx(idx), .byte_mode(byte_q),
    .tgt_addr(addr_q), .tgt_data(data_q),
    .st_wr(st_wr), .st_addr(st_addr), .st_data(st_data), .last_idx(last_idx)
  );

  nor_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .WE_LO_CYC(WE_LO_CYC),
    .WE_HI_CYC(WE_HI_CYC), .RD_LO_CYC(RD_LO_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .start(go), .wr(st_wr), .addr(st_addr),
    .wdata(st_data), .done(bus_done), .rdata(bus_rdata),
    .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n), .addr_o(fl_addr),
    .dq_o(fl_dq_out), .dq_oe(fl_dq_oe), .dq_i(fl_dq_in)
  );
endmodule

// File: rtl/nor_cmd_sequencer_chk.sv
module nor_cmd_sequencer_chk #(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int WE_LO = 5,
  parameter int WE_HI = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done_valid,
  input logic          done_ok,
  input logic          done_timeout,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe
);
  logic [7:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= 8'(WE_HI);
    end else if (!fl_we_n) begin
      lo_cnt <= (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 1'b1;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= '0;
      hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1;
    end
  end

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_we_n || fl_oe_n));
  p_ce_cover_r8: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  p_dq_dir_r8: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_oe_n);
  p_we_width_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (lo_cnt == 8'(WE_LO)));
  p_we_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> (hi_cnt >= 8'(WE_HI)));
  p_we_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |=> (fl_we_n || ($stable(fl_addr) && $stable(fl_dq_out))));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  p_done_excl_r12: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_ok != done_timeout));
  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind nor_cmd_sequencer nor_cmd_sequencer_chk #(
  .AW(AW), .DW(DW), .WE_LO(WE_LO_CYC), .WE_HI(WE_HI_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done_valid(done_valid), .done_ok(done_ok), .done_timeout(done_timeout),
  .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
  .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe)
);

// File: tb/nor_cmd_sequencer_bench.sv
module nor_cmd_sequencer_bench;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int WE_LO = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready, req_toggle = 1'b0, bmode = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          done_valid, done_ok, done_timeout;
  logic [DW-1:0] done_data;
  logic          ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] fa;
  logic [DW-1:0] dq_out, dq_in;

  nor_cmd_sequencer #(
    .AW(AW), .DW(DW), .SETUP_CYC(1), .WE_LO_CYC(WE_LO), .WE_HI_CYC(2),
    .RD_LO_CYC(3), .PROG_TMO(300), .SERASE_TMO(600), .CERASE_TMO(900)
  ) u_nor_cmd_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_poll_toggle(req_toggle), .byte_mode(bmode),
    .done_valid(done_valid), .done_ok(done_ok), .done_timeout(done_timeout),
    .done_data(done_data), .fl_ce_n(ce_n), .fl_we_n(we_n), .fl_oe_n(oe_n),
    .fl_addr(fa), .fl_dq_out(dq_out), .fl_dq_oe(dq_oe), .fl_dq_in(dq_in)
  );

  // flash model
  int            busy_left = 0, n_reads = 0, n_log = 0, bus_viol = 0;
  int            lo_run = 0, lo_bad = 0, dv_run = 0, dv_bad = 0;
  logic          tog = 1'b0;
  logic [DW-1:0] fin = '0;
  logic [AW-1:0] log_a [16];
  logic [DW-1:0] log_d [16];

  assign dq_in = (busy_left > 0) ? {8'h00, ~fin[7], tog, 6'h00} : fin;

  always @(posedge oe_n) if (!rst) begin
    n_reads = n_reads + 1;
    if (busy_left > 0) begin busy_left = busy_left - 1; tog = ~tog; end
  end

  always @(posedge we_n) if (!rst) begin
    if (ce_n || !dq_oe) bus_viol = bus_viol + 1;
    if (n_log < 16) begin log_a[n_log] = fa; log_d[n_log] = dq_out; end
    n_log = n_log + 1;
  end

  always @(negedge clk) if (!rst) begin
    if (!we_n && !oe_n) bus_viol++;
    if ((!we_n || !oe_n) && ce_n) bus_viol++;
    if (dq_oe && !oe_n) bus_viol++;
    if (!we_n) lo_run++;
    else begin
      if (lo_run != 0 && lo_run != WE_LO) lo_bad++;
      lo_run = 0;
    end
    if (done_valid) begin dv_run++; if (dv_run > 1) dv_bad++; end
    else dv_run = 0;
  end

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic        tog;
    logic        bm;
    logic [18:0] addr;
    logic [15:0] data;
    logic [15:0] busy;
    logic [15:0] fin;
    logic        ok;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 1'b0, 19'h01234, 16'h00C3, 16'd3,    16'h00C3, 1'b1},
    '{3'd1, 1'b1, 1'b1, 19'h45678, 16'h0011, 16'd4,    16'h0011, 1'b1},
    '{3'd2, 1'b0, 1'b0, 19'h00400, 16'h0000, 16'd5,    16'hFFFF, 1'b1},
    '{3'd3, 1'b1, 1'b1, 19'h00000, 16'h0000, 16'd6,    16'hFFFF, 1'b1},
    '{3'd0, 1'b0, 1'b0, 19'h00010, 16'h0000, 16'd0,    16'h0000, 1'b1},
    '{3'd4, 1'b0, 1'b0, 19'h00000, 16'h0000, 16'd0,    16'h0040, 1'b1},
    '{3'd4, 1'b0, 1'b1, 19'h00002, 16'h0000, 16'd0,    16'h00B3, 1'b1},
    '{3'd6, 1'b0, 1'b1, 19'h00100, 16'h0000, 16'd0,    16'h0000, 1'b1},
    '{3'd1, 1'b0, 1'b0, 19'h00777, 16'h0005, 16'd2,    16'h0005, 1'b1},
    '{3'd2, 1'b0, 1'b0, 19'h00800, 16'h0000, 16'd2000, 16'hFFFF, 1'b0},
    '{3'd1, 1'b1, 1'b0, 19'h00020, 16'h0077, 16'd2000, 16'h0077, 1'b0}
  };

  logic [AW-1:0] ex_a [16];
  logic [DW-1:0] ex_d [16];
  int            ex_n;

  task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
    ex_a[ex_n] = a; ex_d[ex_n] = {8'h00, d}; ex_n++;
  endtask

  task automatic build_exp(input vec_t v);
    logic [AW-1:0] ka, kb;
    ka = v.bm ? 19'h0AAAA : 19'h05555;   // R4
    kb = v.bm ? 19'h05555 : 19'h02AAA;
    ex_n = 0;
    case (v.op)
      3'd1: begin
        push(ka, 8'hAA); push(kb, 8'h55); push(ka, 8'hA0);
        ex_a[ex_n] = v.addr; ex_d[ex_n] = v.data; ex_n++;
      end
      3'd2, 3'd3: begin
        push(ka, 8'hAA); push(kb, 8'h55); push(ka, 8'h80);
        push(ka, 8'hAA); push(kb, 8'h55);
        if (v.op == 3'd2) push(v.addr, 8'h30); else push(ka, 8'h10);
      end
      3'd4: begin
        push(ka, 8'hAA); push(kb, 8'h55); push(ka, 8'h90); push(ka, 8'hF0);
      end
      default: push(ka, 8'hF0);
    endcase
    if (!v.ok) push(ka, 8'hF0);   // R11 abort write
  endtask

  function automatic string seq_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R2/R4";
      3'd2, 3'd3: return "R3/R4";
      3'd4: return "R6/R4";
      default: return "R5/R4";
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    int  wd;
    bit  seq_ok;
    @(negedge clk);
    busy_left = int'(v.busy); fin = v.fin; tog = 1'b0;
    n_reads = 0; n_log = 0;
    req_op = v.op; req_toggle = v.tog; bmode = v.bm;
    req_addr = v.addr; req_data = v.data; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready low while busy", req_ready, 0);
    wd = 0;
    while (!done_valid && wd < 20000) begin @(negedge clk); wd++; end
    if (!done_valid) begin
      chk(1'b0, "R1", "watchdog waiting for done", 0, 1);
      return;
    end
    chk(req_ready == 1'b1, "R1", "ready with done", req_ready, 1);
    if (v.ok) chk(done_ok && !done_timeout, v.tog ? "R10" : "R9",
                  "completion status", {done_ok, done_timeout}, 2'b10);
    else      chk(!done_ok && done_timeout, "R11", "timeout status",
                  {done_ok, done_timeout}, 2'b01);
    build_exp(v);
    seq_ok = (n_log == ex_n);
    for (int i = 0; i < ex_n && i < 16 && seq_ok; i++)
      if (log_a[i] != ex_a[i] || log_d[i] != ex_d[i]) seq_ok = 0;
    chk(seq_ok, v.ok ? seq_tag(v.op) : "R11", "write sequence / count",
        n_log, ex_n);
    if (!seq_ok)
      for (int i = 0; i < n_log && i < 16; i++)
        $display("  write %0d: %0h <= %0h", i, log_a[i], log_d[i]);
    if (v.op == 3'd4)
      chk(done_data == v.fin && n_reads == 1, "R6", "identifier value",
          done_data, v.fin);
    if (v.ok && !v.tog && (v.op == 3'd1 || v.op == 3'd2 || v.op == 3'd3))
      chk(n_reads == int'(v.busy) + 1, "R9", "poll read count",
          n_reads, int'(v.busy) + 1);
    if (v.ok && v.tog)
      chk(n_reads >= int'(v.busy) + 1 && n_reads <= int'(v.busy) + 2,
          "R10", "toggle read count", n_reads, int'(v.busy) + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done_valid && ce_n && we_n && oe_n && !dq_oe, "R1",
        "reset state", {req_ready, done_valid, ce_n, we_n, oe_n, dq_oe},
        6'b101110);
    for (int k = 0; k < NV; k++) run_vec(VEC[k]);
    // directed: program where final bit 7 matches only after busy in byte mode
    run_vec('{3'd1, 1'b0, 1'b1, 19'h7FFFF, 16'h0080, 16'd1, 16'h0080, 1'b1});
    // directed: chip erase timeout (R11) with toggle polling never settling
    run_vec('{3'd3, 1'b1, 1'b0, 19'h00000, 16'h0000, 16'd3000, 16'hFFFF, 1'b0});
    chk(bus_viol == 0, "R8", "strobe overlap / drive violations", bus_viol, 0);
    chk(lo_bad == 0, "R7", "write-enable low width", lo_bad, 0);
    chk(dv_bad == 0, "R12", "done pulse width", dv_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 global watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule